// File: doc/BRIEF.md
# Serial EEPROM Paged Transfer Sequencer

This block moves a buffer of bytes between the user side of a chip and an external serial EEPROM over a four-wire SPI link. The user provides a start address, a byte count and a direction, then pulses `start`. On a write, the block pulls bytes through a valid/ready stream. It cuts the buffer into pieces that never cross a 16-byte page. For each piece it runs the same steps: a one-byte write-enable transaction, a page program transaction, and then status polling until the device reports ready. On a read, the block opens one chip-select window. It sends the read command and the address, then clocks one dummy byte for each requested byte, and hands every returned data byte to the user as a one-cycle pulse.

The serial clock is built by a parameterised divider from the system clock. The default gives 1 MHz from 100 MHz. The link runs SPI mode 0: the clock idles low, data is sampled on the rising edge, and frames are 8 bits, most significant bit first. Chip select stays high for at least one full serial clock period between transactions. When a transfer ends, `done` pulses for one cycle. If the device stays busy through too many status reads, `timeout` is raised in the same cycle as `done`.

Top module: `eeprom_page_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, and `done`, `timeout`, `wr_ready` and `rd_valid` are 0.
- R2: Bytes are shifted MSB first in SPI mode 0. `sck` is 0 whenever `cs_n` is 1, and each `sck` level lasts at least HALF_DIV system clocks.
- R3: Every page program is preceded by its own transaction that carries only the byte 0x06. Chip select rises between that transaction and the program.
- R4: A page program carries 0x02, then address bits 15..8, then address bits 7..0, then 1 to 16 data bytes that stay inside one 16-byte page. An unaligned start ends its first piece at the page end, and each later piece starts at the previous start plus the previous piece length. Chip select rises only while `sck` is low, after the last bit of the last byte.
- R5: After each page program, the block repeats the transaction 0x05, 0x00 and reads bit 0 of the second returned byte. It moves on only after a read in which bit 0 is 0.
- R6: After POLL_MAX status reads that all show bit 0 set, the block stops. It raises `timeout` in the same cycle as `done` and issues no further pages of that transfer. `timeout` is never high without `done`.
- R7: A read sends 0x03, address bits 15..8, address bits 7..0 and then `len` bytes of 0x00, all in one chip-select window. The first three received bytes are dropped, and each later byte appears on `rd_data` with a one-cycle `rd_valid`, in address order.
- R8: Chip select stays high for at least 2*HALF_DIV system clocks between any two transactions.
- R9: `done` is high for exactly one clock per accepted transfer. `timeout` is 0 on a transfer that finishes normally.
- R10: A `start` pulse that arrives while a transfer is running is ignored: no extra transaction is started and no extra `done` is produced.
- R11: A transfer with `len` = 0 produces `done` without any chip-select activity.
- R12: A write byte is consumed in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while chip select is low and `sck` is low, and the sequencer waits for as long as `wr_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled only when idle) |
| rnw | input | 1 | 1 = read from device, 0 = write to device |
| addr | input | 16 | Start byte address |
| len | input | LEN_W | Number of bytes to move |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write data byte available |
| wr_ready | output | 1 | Sequencer takes the write byte this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| done | output | 1 | One-cycle end-of-transfer pulse |
| timeout | output | 1 | Status polling gave up; high with `done` |
| sck | output | 1 | Serial clock to device |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |

## Verification
The bound assertions check the electrical and timing rules on every cycle. These are: the serial clock idles low outside chip select, its half-period minimum holds, chip select has a minimum high gap and rises only while the clock is low, `done` and `rd_valid` are single-cycle pulses, `timeout` never appears without `done`, and write data is requested only inside a transaction. The rest can only be shown by the bench scenarios, which run against a behavioural EEPROM that decodes the bus. Those scenarios cover page splitting at unaligned addresses, the write-enable before every program, the number of status polls against the device's busy time, the removal of the echo bytes on reads, abandonment after a timeout, and a `start` pulse ignored mid-transfer.

// File: rtl/eeprom_seq_pkg.sv
// Package: shared constants and state encodings for the paged EEPROM
// sequencer. Assumes 16-bit device addressing and 8-bit SPI frames.
package eeprom_seq_pkg;
    localparam int ADDR_W = 16;

    localparam logic [7:0] OP_WEN    = 8'h06;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_FETCH  = 8'h03;
    localparam logic [7:0] FILL_BYTE = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_LOAD,
        ST_SHIFT,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        TX_WEN,
        TX_PROG,
        TX_STATUS,
        TX_FETCH
    } txn_kind_t;
endpackage

// File: rtl/seq_sck_timer.sv
// Module: half-period timer for the serial clock. It emits a one-cycle
// tick every HALF_DIV system clocks and restarts from zero while clr is held.
// Assumes HALF_DIV >= 1.
module seq_sck_timer #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST) && !clr;

    // Count system clocks within one serial clock half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/seq_spi_shifter.sv
// Module: one 8-bit SPI mode-0 frame, MSB first. go loads a byte. The
// first tick raises sck and samples miso, the next lowers sck and moves the
// next bit onto mosi. done pulses one cycle after the eighth falling edge.
// Assumes go only arrives while no frame is active.
module seq_spi_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       done
);
    logic       active;
    logic [7:0] tx_sr;
    logic [2:0] bit_cnt;

    assign mosi = tx_sr[7];

    // Walk the sixteen half-periods of one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sck     <= 1'b0;
            tx_sr   <= '0;
            rx_byte <= '0;
            bit_cnt <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active  <= 1'b1;
                sck     <= 1'b0;
                tx_sr   <= tx_byte;
                bit_cnt <= '0;
            end else if (active && tick) begin
                if (!sck) begin
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        tx_sr   <= {tx_sr[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/seq_chunk_calc.sv
// Module: size of the next page program. This is the smaller of the bytes
// still to write and the room left in the current page. A power-of-two page
// uses an address slice; any other size uses a modulo.
// Assumes 2 <= PAGE_BYTES < 2**LEN_W.
module seq_chunk_calc #(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 11,
    parameter int PAGE_BYTES = 16
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  remaining,
    output logic [LEN_W-1:0]  chunk
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);

    logic [LEN_W-1:0] offset;
    logic [LEN_W-1:0] room;

    generate
        if ((1 << OFF_W) == PAGE_BYTES) begin : g_pow2
            assign offset = LEN_W'(cur_addr[OFF_W-1:0]);
        end else begin : g_mod
            assign offset = LEN_W'(cur_addr % ADDR_W'(PAGE_BYTES));
        end
    endgenerate

    assign room  = PAGE_L - offset;
    assign chunk = (remaining < room) ? remaining : room;
endmodule

// File: rtl/eeprom_page_seq.sv
// Module: top of the paged EEPROM sequencer. It accepts a transfer when
// idle. Writes run as write-enable, page program and status polling for
// each page piece. Reads run as one fetch transaction whose first three
// returned bytes are dropped. Assumes the device uses SPI mode 0 and
// answers status with the busy flag in bit 0.
module eeprom_page_seq
    import eeprom_seq_pkg::*;
#(
    parameter int HALF_DIV   = 50,
    parameter int LEN_W      = 11,
    parameter int PAGE_BYTES = 16,
    parameter int POLL_MAX   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rnw,
    input  logic [15:0]       addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              timeout,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int IDX_W = LEN_W + 1;
    localparam int PC_W  = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
    localparam logic [PC_W-1:0]  POLL_LAST = PC_W'(POLL_MAX - 1);
    localparam logic [IDX_W-1:0] HDR_LEN   = IDX_W'(3);

    seq_state_t          state;
    txn_kind_t           txn;
    logic [ADDR_W-1:0]   cur_addr;
    logic [LEN_W-1:0]    remaining;
    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    txn_len;
    logic [PC_W-1:0]     poll_cnt;
    logic                gap_half;
    logic                abort_r;
    logic [LEN_W-1:0]    chunk;
    logic [7:0]          tx_byte;
    logic [7:0]          rx_byte;
    logic                need_data;
    logic                go;
    logic                tick;
    logic                tmr_clr;
    logic                sh_done;
    logic                last_byte;

    seq_sck_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tick)
    );

    seq_spi_shifter u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tx_byte (tx_byte),
        .tick    (tick),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .rx_byte (rx_byte),
        .done    (sh_done)
    );

    seq_chunk_calc #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_chunk (
        .cur_addr  (cur_addr),
        .remaining (remaining),
        .chunk     (chunk)
    );

    // Byte count of the transaction in progress.
    always_comb begin
        case (txn)
            TX_WEN:    txn_len = IDX_W'(1);
            TX_PROG:   txn_len = IDX_W'(chunk) + HDR_LEN;
            TX_STATUS: txn_len = IDX_W'(2);
            default:   txn_len = IDX_W'(remaining) + HDR_LEN;
        endcase
    end

    // Byte to shift out at position idx of the transaction.
    always_comb begin
        case (txn)
            TX_WEN:    tx_byte = OP_WEN;
            TX_STATUS: tx_byte = (idx == '0) ? OP_STATUS : FILL_BYTE;
            default: begin
                if (idx == IDX_W'(0))      tx_byte = (txn == TX_PROG) ? OP_PROG : OP_FETCH;
                else if (idx == IDX_W'(1)) tx_byte = cur_addr[15:8];
                else if (idx == IDX_W'(2)) tx_byte = cur_addr[7:0];
                else                       tx_byte = (txn == TX_PROG) ? wr_data : FILL_BYTE;
            end
        endcase
    end

    assign need_data = (state == ST_LOAD) && (txn == TX_PROG) && (idx >= HDR_LEN);
    assign wr_ready  = need_data;
    assign go        = (state == ST_LOAD) && (!need_data || wr_valid);
    assign tmr_clr   = !((state == ST_GAP) || (state == ST_SHIFT && !sh_done));
    assign last_byte = (idx == txn_len - IDX_W'(1));
    assign done      = (state == ST_FINISH);
    assign timeout   = done && abort_r;

    // Transfer sequencing: transactions, page advance, polling and delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            txn       <= TX_WEN;
            cur_addr  <= '0;
            remaining <= '0;
            idx       <= '0;
            poll_cnt  <= '0;
            gap_half  <= 1'b0;
            abort_r   <= 1'b0;
            cs_n      <= 1'b1;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_addr  <= addr;
                        remaining <= len;
                        abort_r   <= 1'b0;
                        gap_half  <= 1'b0;
                        txn       <= rnw ? TX_FETCH : TX_WEN;
                        state     <= (len == '0) ? ST_FINISH : ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            cs_n  <= 1'b0;
                            idx   <= '0;
                            state <= ST_LOAD;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    if (go) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (sh_done) begin
                        if (txn == TX_FETCH && idx >= HDR_LEN) begin
                            rd_valid <= 1'b1;
                            rd_data  <= rx_byte;
                        end
                        if (!last_byte) begin
                            idx   <= idx + IDX_W'(1);
                            state <= ST_LOAD;
                        end else begin
                            cs_n     <= 1'b1;
                            gap_half <= 1'b0;
                            state    <= ST_GAP;
                            case (txn)
                                TX_WEN: txn <= TX_PROG;
                                TX_PROG: begin
                                    cur_addr  <= cur_addr + ADDR_W'(chunk);
                                    remaining <= remaining - chunk;
                                    poll_cnt  <= '0;
                                    txn       <= TX_STATUS;
                                end
                                TX_STATUS: begin
                                    if (!rx_byte[0]) begin
                                        if (remaining == '0) state <= ST_FINISH;
                                        else                 txn   <= TX_WEN;
                                    end else if (poll_cnt == POLL_LAST) begin
                                        abort_r <= 1'b1;
                                        state   <= ST_FINISH;
                                    end else begin
                                        poll_cnt <= poll_cnt + PC_W'(1);
                                    end
                                end
                                default: state <= ST_FINISH;
                            endcase
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seq_checker.sv
// Module: cycle-level protocol checks for eeprom_page_seq, attached by bind.
// It keeps small counters of its own for the half-period and gap windows.
module seq_checker #(
    parameter int HALF_DIV = 50
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic done,
    input logic timeout,
    input logic wr_ready,
    input logic rd_valid
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic        sck_q;
    logic        cs_q;
    logic [15:0] hold;
    logic [15:0] cs_hi;

    // Track how long sck and chip select have kept their levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
            hold  <= SAT;
            cs_hi <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (sck != sck_q)   hold <= 16'd1;
            else if (hold != SAT) hold <= hold + 16'd1;
            if (!cs_n)           cs_hi <= '0;
            else if (cs_hi != SAT) cs_hi <= cs_hi + 16'd1;
        end
    end

    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    p_sck_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != sck_q) |-> (hold >= 16'(HALF_DIV)));
    p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q && !cs_n) |-> (cs_hi >= 16'(2 * HALF_DIV)));
    p_cs_rise_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_q && cs_n) |-> !sck);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_timeout_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);
    p_wr_ready_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!cs_n && !sck));
    p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind eeprom_page_seq seq_checker #(.HALF_DIV(HALF_DIV)) u_seq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .done     (done),
    .timeout  (timeout),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid)
);

// File: tb/tb_eeprom_page_seq.sv
// Bench: drives eeprom_page_seq against a behavioural serial EEPROM that
// decodes the bus on sck edges, sampled at the falling system clock.
module tb_eeprom_page_seq;
    localparam int HD    = 2;
    localparam int LEN_W = 11;
    localparam int PMAX  = 4;

    typedef struct packed {
        logic        rnw;
        logic [15:0] addr;
        logic [10:0] len;
        logic [7:0]  busy;
        logic [3:0]  pages;
        logic        stall;
        logic [7:0]  seed;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 16'h0200, 11'd20, 8'd1, 4'd2, 1'b0, 8'h11},
        '{1'b0, 16'h020E, 11'd5,  8'd0, 4'd2, 1'b1, 8'h22},
        '{1'b0, 16'h0305, 11'd1,  8'd2, 4'd1, 1'b0, 8'h33},
        '{1'b0, 16'h0310, 11'd16, 8'd0, 4'd1, 1'b1, 8'h44},
        '{1'b1, 16'h0200, 11'd20, 8'd0, 4'd0, 1'b0, 8'h00},
        '{1'b1, 16'h0300, 11'd32, 8'd0, 4'd0, 1'b0, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rnw = 1'b0;
    logic [15:0] addr = '0;
    logic [LEN_W-1:0] len = '0;
    logic [7:0] wr_data = '0;
    logic wr_valid = 1'b0;
    logic wr_ready, rd_valid, done, timeout, sck, cs_n, mosi, miso;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    eeprom_page_seq #(.HALF_DIV(HD), .LEN_W(LEN_W), .PAGE_BYTES(16), .POLL_MAX(PMAX)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rnw(rnw), .addr(addr), .len(len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .timeout(timeout),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // Shared transfer context, written only by the main process.
    int         xfer_id = 0;
    logic [7:0] cur_busy = '0;
    logic       cur_stall = 1'b0;
    logic [7:0] cur_seed = '0;
    logic [9:0] cur_base = '0;
    logic       w_active = 1'b0;
    logic [7:0] exp_mem [1024];

    function automatic logic [7:0] pat(input logic [9:0] a, input logic [7:0] s);
        pat = (a[7:0] * 8'd7) ^ s ^ {6'd0, a[9:8]};
    endfunction

    // Behavioural EEPROM model.
    logic [7:0]  m_mem [1024];
    logic [7:0]  m_buf [32];
    logic [7:0]  m_sr_in = '0, m_sr_out = '0, m_cmd = '0;
    logic [15:0] m_addr = '0, m_raddr = '0;
    int m_bit = 0, m_nbytes = 0, m_wcount = 0, m_busy_left = 0, m_cs_high = 1000;
    logic m_wel = 1'b0, m_cs_q = 1'b1, m_sck_q = 1'b0;
    int n_wren = 0, n_write = 0, n_poll = 0, n_read = 0, n_txn = 0;
    int nowel_write = 0, page_bad = 0, gap_bad = 0;
    logic [15:0] m_wlog_addr [8];
    int          m_wlog_len [8];

    assign miso = m_sr_out[7];

    always @(negedge clk) begin
        if (m_cs_q && !cs_n) begin
            if (m_cs_high < 2 * HD) gap_bad++;
            n_txn++;
            m_bit = 0; m_nbytes = 0; m_wcount = 0; m_sr_out = '0;
        end
        if (!cs_n && !m_sck_q && sck) begin
            m_sr_in = {m_sr_in[6:0], mosi};
            m_bit++;
            if (m_bit == 8) begin
                m_bit = 0;
                if (m_nbytes == 0) begin
                    m_cmd = m_sr_in;
                    if (m_sr_in == 8'h05) m_sr_out = {7'd0, m_busy_left != 0};
                end else if (m_nbytes == 1) begin
                    m_addr[15:8] = m_sr_in;
                end else if (m_nbytes == 2) begin
                    m_addr[7:0] = m_sr_in;
                    if (m_cmd == 8'h03) begin
                        m_sr_out = m_mem[m_addr[9:0]];
                        m_raddr  = m_addr + 16'd1;
                    end
                end else begin
                    if (m_cmd == 8'h02) begin
                        if (m_wcount < 32) m_buf[m_wcount] = m_sr_in;
                        m_wcount++;
                    end else if (m_cmd == 8'h03) begin
                        m_sr_out = m_mem[m_raddr[9:0]];
                        m_raddr  = m_raddr + 16'd1;
                    end
                end
                m_nbytes++;
            end
        end
        if (!cs_n && m_sck_q && !sck && m_bit != 0) m_sr_out = {m_sr_out[6:0], 1'b0};
        if (!m_cs_q && cs_n && m_bit == 0) begin
            if (m_cmd == 8'h06 && m_nbytes == 1) begin
                m_wel = 1'b1; n_wren++;
            end else if (m_cmd == 8'h02 && m_nbytes >= 3) begin
                if (m_wel) begin
                    m_wlog_addr[n_write % 8] = m_addr;
                    m_wlog_len[n_write % 8]  = m_wcount;
                    if (m_wcount > 16 || (int'(m_addr[3:0]) + m_wcount) > 16) page_bad++;
                    for (int k = 0; k < m_wcount && k < 32; k++)
                        m_mem[{m_addr[9:4], 4'(m_addr[3:0] + 4'(k))}] = m_buf[k];
                    m_wel = 1'b0;
                    m_busy_left = int'(cur_busy);
                end else begin
                    nowel_write++;
                end
                n_write++;
            end else if (m_cmd == 8'h05 && m_nbytes == 2) begin
                n_poll++;
                if (m_busy_left > 0) m_busy_left--;
            end else if (m_cmd == 8'h03) begin
                n_read++;
            end
        end
        if (cs_n) m_cs_high++; else m_cs_high = 0;
        m_cs_q  = cs_n;
        m_sck_q = sck;
    end

    // Write data source: byte for each address, optional stall after each take.
    int w_seen = -1, w_idx = 0, w_stall = 0;
    logic w_took = 1'b0;
    always @(negedge clk) begin
        if (w_seen != xfer_id) begin
            w_seen = xfer_id; w_idx = 0; w_stall = 0; w_took = 1'b0;
        end
        if (w_took) begin
            w_idx++;
            w_stall = cur_stall ? 3 : 0;
        end
        if (w_stall > 0) begin
            wr_valid = 1'b0; w_stall--;
        end else begin
            wr_valid = w_active;
        end
        wr_data = pat(cur_base + 10'(w_idx), cur_seed);
        w_took = wr_ready && wr_valid;
    end

    // Read data sink: compare every delivered byte with the expected memory.
    int r_seen = -1, r_cnt = 0, r_bad = 0;
    always @(negedge clk) begin
        if (r_seen != xfer_id) begin
            r_seen = xfer_id; r_cnt = 0; r_bad = 0;
        end
        if (rd_valid) begin
            if (rd_data != exp_mem[cur_base + 10'(r_cnt)]) r_bad++;
            r_cnt++;
        end
    end

    int n_checks = 0, n_fail = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output logic tmo);
        int k = 0;
        while (!done && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk("R9 watchdog done reached", int'(k < 20000), 1);
        tmo = timeout;
        @(negedge clk);
        chk("R9 done one cycle", int'(done), 0);
    endtask

    task automatic launch(input logic r, input logic [15:0] a, input logic [10:0] l,
                          input logic [7:0] b, input logic st, input logic [7:0] s);
        cur_busy = b; cur_stall = st; cur_seed = s; cur_base = a[9:0];
        xfer_id++;
        @(negedge clk);
        start = 1'b1; rnw = r; addr = a; len = LEN_W'(l); w_active = !r;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic fill_exp(input logic [15:0] a, input int l, input logic [7:0] s);
        for (int i = 0; i < l; i++) exp_mem[a[9:0] + 10'(i)] = pat(a[9:0] + 10'(i), s);
    endtask

    task automatic mem_diff(input logic [15:0] a, input int l, output int bad);
        bad = 0;
        for (int i = 0; i < l; i++)
            if (m_mem[a[9:0] + 10'(i)] != exp_mem[a[9:0] + 10'(i)]) bad++;
    endtask

    initial begin
        logic tmo;
        int s_wren, s_write, s_poll, s_read, s_txn, bad, first_len, extra;
        for (int i = 0; i < 1024; i++) begin
            m_mem[i] = 8'h00; exp_mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: idle state under reset and just after.
        chk("R1 cs_n in reset", int'(cs_n), 1);
        chk("R1 sck in reset", int'(sck), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done/timeout idle", int'({done, timeout}), 0);
        chk("R1 wr_ready/rd_valid idle", int'({wr_ready, rd_valid}), 0);

        for (int v = 0; v < 6; v++) begin
            vec_t cv;
            cv = VECS[v];
            s_wren = n_wren; s_write = n_write; s_poll = n_poll; s_read = n_read;
            launch(cv.rnw, cv.addr, cv.len, cv.busy, cv.stall, cv.seed);
            wait_done(tmo);
            chk("R9 no timeout on normal end", int'(tmo), 0);
            if (!cv.rnw) begin
                fill_exp(cv.addr, int'(cv.len), cv.seed);
                first_len = 16 - int'(cv.addr[3:0]);
                if (first_len > int'(cv.len)) first_len = int'(cv.len);
                chk("R3 one write-enable per page", n_wren - s_wren, int'(cv.pages));
                chk("R3 no program without enable", nowel_write, 0);
                chk("R4 page programs", n_write - s_write, int'(cv.pages));
                chk("R4 first piece address", int'(m_wlog_addr[s_write % 8]), int'(cv.addr));
                chk("R4 first piece length", m_wlog_len[s_write % 8], first_len);
                if (cv.pages > 1)
                    chk("R4 next piece aligned", int'(m_wlog_addr[(s_write + 1) % 8]),
                        int'(cv.addr) + first_len);
                chk("R4 no page crossing", page_bad, 0);
                chk("R5 status polls", n_poll - s_poll, int'(cv.pages) * (int'(cv.busy) + 1));
                mem_diff(cv.addr, int'(cv.len), bad);
                chk("R12 written data", bad, 0);
            end else begin
                chk("R7 one fetch transaction", n_read - s_read, 1);
                chk("R7 bytes delivered", r_cnt, int'(cv.len));
                chk("R7 delivered data", r_bad, 0);
                chk("R7 no program on read", n_write - s_write, 0);
            end
            chk("R8 chip select gap", gap_bad, 0);
        end

        // R11: zero length finishes without bus activity.
        s_txn = n_txn;
        launch(1'b0, 16'h0040, 11'd0, 8'd0, 1'b0, 8'h55);
        chk("R11 done right after start", int'(done), 1);
        wait_done(tmo);
        chk("R11 no transaction", n_txn - s_txn, 0);

        // R10: a second start during a transfer is ignored.
        s_write = n_write; s_read = n_read;
        launch(1'b0, 16'h0040, 11'd3, 8'd0, 1'b0, 8'h66);
        repeat (40) @(negedge clk);
        start = 1'b1; rnw = 1'b1; addr = 16'h0000; len = LEN_W'(5);
        @(negedge clk);
        start = 1'b0;
        wait_done(tmo);
        extra = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R10 no extra done", extra, 0);
        chk("R10 no read started", n_read - s_read, 0);
        chk("R10 single program", n_write - s_write, 1);
        fill_exp(16'h0040, 3, 8'h66);
        mem_diff(16'h0040, 3, bad);
        chk("R10 first transfer intact", bad, 0);

        // R6: device stays busy, sequencer gives up after POLL_MAX reads.
        s_write = n_write; s_poll = n_poll; s_wren = n_wren;
        launch(1'b0, 16'h0100, 11'd20, 8'd10, 1'b0, 8'h77);
        wait_done(tmo);
        chk("R6 timeout with done", int'(tmo), 1);
        chk("R6 poll count", n_poll - s_poll, PMAX);
        chk("R6 later pages abandoned", n_write - s_write, 1);
        chk("R6 no further enable", n_wren - s_wren, 1);
        chk("R2 sck idle after run", int'(sck), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule